// File: doc/BRIEF.md
# Cache Victim Slot Selector

This block chooses which slot of a small fully associative cache gets overwritten by the next line fill. It does not hold tags or data. It keeps a replacement pointer and presents it on `victim_o` as a registered index. The cache controller reads that index, writes the new line into the named slot, and pulses `fill_i` in the same cycle. That pulse consumes the index, and the block loads the next one.

Two replacement policies are built in, and `mode_i` picks between them at each fill.

- **Sweep:** a pointer climbs from the lowest slot to the highest, then walks back down, turning at each end without revisiting the end slot.
- **Random:** the index comes from a six-bit maximal-length shift register whose single out-of-range value is folded onto slot 0.

Each policy keeps its own state, and a fill under one policy leaves the other untouched. A flush pulse, issued when the cache is emptied, restarts the sweep at slot 0 going upward.

Top module: `cache_victim_selector`

## Requirements
- R1: In the cycle after synchronous reset is released, `victim_o` is 0. The sweep pointer is at slot 0 heading upward, and the random register holds the value 1.
- R2: `victim_o` changes only on the clock edge where `fill_i` or `flush_i` is high. With both low it holds its value whatever `mode_i` does.
- R3: With `mode_i`=0, each fill moves the sweep one slot and loads the new position into `victim_o`. From reset the loaded indices are 1, 2, …, 62, 61, …, 1, 0, 1, 2, and so on. Neither end slot is repeated at a turn.
- R4: With `mode_i`=1, each fill advances a 6-bit register s to {s[4:0], s[5]^s[4]} and loads s into `victim_o`, except that s=63 loads 0.
- R5: Any 63 consecutive fills made with `mode_i`=1 and no flush between them load each index 0..62 exactly once.
- R6: `victim_o` never exceeds 62.
- R7: A flush loads 0 into `victim_o` on the next edge and restarts the sweep at 0 heading upward. Flush wins over a fill in the same cycle. Flush leaves the random register unchanged.
- R8: A fill under one policy does not change the state of the other policy. After any number of random fills, the next sweep fill continues from where the sweep stopped, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Policy for the current fill: 0 sweep, 1 random |
| fill_i | input | 1 | One cycle per line fill; consumes the current index |
| flush_i | input | 1 | Cache emptied; restarts the sweep |
| victim_o | output | 6 | Slot that the next fill overwrites |

## Verification
The assertions take for granted that `fill_i` and `flush_i` are sampled as plain level strobes on each edge. They assume that `mode_i` may change on any cycle and that both strobes may be high together. They make no assumption about how often fills arrive. The stimulus therefore drives all three inputs freely on the falling edge from a seeded `$urandom`, with flushes kept rare so that long sweeps and full random periods still occur. Directed runs then force a complete up-and-down sweep, a full random period, a flush colliding with a fill, and policy switches mid-sweep.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } sweep_dir_e;

  typedef enum logic {
    POL_SWEEP  = 1'b0,
    POL_RANDOM = 1'b1
  } policy_e;
endpackage

// File: rtl/cvs_sweep.sv
module cvs_sweep
  import cvs_pkg::*;
#(
  parameter int NUM_SLOTS = 63,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] pos_q,
  output logic [IDX_W-1:0] pos_nxt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  sweep_dir_e dir_q, dir_nxt;

  always_comb begin
    pos_nxt = pos_q;
    dir_nxt = dir_q;
    if (clr) begin
      pos_nxt = '0;
      dir_nxt = DIR_UP;
    end else if (step) begin
      if (dir_q == DIR_UP) begin
        if (pos_q == LAST) begin
          pos_nxt = LAST - 1'b1;
          dir_nxt = DIR_DOWN;
        end else begin
          pos_nxt = pos_q + 1'b1;
        end
      end else begin
        if (pos_q == '0) begin
          pos_nxt = IDX_W'(1);
          dir_nxt = DIR_UP;
        end else begin
          pos_nxt = pos_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      pos_q <= pos_nxt;
      dir_q <= dir_nxt;
    end
  end

  // R3
  sweep_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> ((pos_q == $past(pos_q) + 1'b1) || (pos_q + 1'b1 == $past(pos_q))));

  // R8
  sweep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> ($stable(pos_q) && $stable(dir_q)));

  // R7
  sweep_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pos_q == '0 && dir_q == DIR_UP));
endmodule

// File: rtl/cvs_lfsr.sv
module cvs_lfsr #(
  parameter int           W    = 6,
  parameter logic [W-1:0] TAPS = 6'b110000,
  parameter logic [W-1:0] SEED = 6'd1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_nxt
);
  logic fb;

  always_comb begin
    fb        = ^(state_q & TAPS);
    state_nxt = step ? {state_q[W-2:0], fb} : state_q;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_nxt;
  end

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state_q));
endmodule

// File: rtl/cache_victim_selector.sv
module cache_victim_selector
  import cvs_pkg::*;
#(
  parameter int NUM_SLOTS = 63,
  parameter int IDX_W     = 6,
  parameter logic [IDX_W-1:0] LFSR_TAPS = 6'b110000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             fill_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] SLOTS_W = IDX_W'(NUM_SLOTS);

  policy_e          policy;
  logic             sweep_step, rand_step;
  logic [IDX_W-1:0] sweep_pos, sweep_nxt;
  logic [IDX_W-1:0] rand_state, rand_nxt;
  logic [IDX_W-1:0] rand_idx;
  logic [IDX_W-1:0] victim_q;

  assign policy     = policy_e'(mode_i);
  assign sweep_step = fill_i && (policy == POL_SWEEP);
  assign rand_step  = fill_i && !flush_i && (policy == POL_RANDOM);

  cvs_sweep #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) sweep_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (flush_i),
    .step    (sweep_step),
    .pos_q   (sweep_pos),
    .pos_nxt (sweep_nxt)
  );

  cvs_lfsr #(
    .W    (IDX_W),
    .TAPS (LFSR_TAPS)
  ) lfsr_i (
    .clk       (clk),
    .rst       (rst),
    .step      (rand_step),
    .state_q   (rand_state),
    .state_nxt (rand_nxt)
  );

  // fold values past the last slot back into range
  always_comb begin
    if (rand_nxt >= SLOTS_W) rand_idx = rand_nxt - SLOTS_W;
    else                     rand_idx = rand_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      victim_q <= '0;
    end else if (fill_i) begin
      victim_q <= (policy == POL_RANDOM) ? rand_idx : sweep_nxt;
    end
  end

  assign victim_o = victim_q;

  // R6
  victim_range_chk: assert property (@(posedge clk) disable iff (rst)
    victim_o < SLOTS_W);

  // R2
  victim_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!fill_i && !flush_i) |=> $stable(victim_o));

  // R7
  victim_flush_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (victim_o == '0));

  // R7
  flush_keeps_lfsr_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> $stable(rand_state));
endmodule

// File: tb/cache_victim_selector_tb_top.sv
module cache_victim_selector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_i = 1'b0;
  logic       fill_i = 1'b0;
  logic       flush_i = 1'b0;
  logic [5:0] victim_o;

  int total = 0;
  int bad   = 0;

  logic [5:0] m_pos  = 6'd0;
  logic       m_up   = 1'b1;
  logic [5:0] m_lfsr = 6'd1;
  logic [5:0] m_vict = 6'd0;

  always #10 clk = ~clk;

  cache_victim_selector dut_i (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode_i),
    .fill_i   (fill_i),
    .flush_i  (flush_i),
    .victim_o (victim_o)
  );

  function automatic logic [5:0] lfsr_next(input logic [5:0] s);
    return {s[4:0], s[5] ^ s[4]};
  endfunction

  function automatic logic [5:0] fold63(input logic [5:0] s);
    return (s == 6'd63) ? 6'd0 : s;
  endfunction

  task automatic check(input logic [5:0] act, input logic [5:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: victim_o=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic md, input logic f, input logic fl);
    if (fl) begin
      m_pos  = 6'd0;
      m_up   = 1'b1;
      m_vict = 6'd0;
    end else if (f) begin
      if (!md) begin
        if (m_up) begin
          if (m_pos == 6'd62) begin m_pos = 6'd61; m_up = 1'b0; end
          else m_pos = m_pos + 6'd1;
        end else begin
          if (m_pos == 6'd0) begin m_pos = 6'd1; m_up = 1'b1; end
          else m_pos = m_pos - 6'd1;
        end
        m_vict = m_pos;
      end else begin
        m_lfsr = lfsr_next(m_lfsr);
        m_vict = fold63(m_lfsr);
      end
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic cyc(input logic md, input logic f, input logic fl, input string req);
    mode_i  = md;
    fill_i  = f;
    flush_i = fl;
    @(negedge clk);
    model_update(md, f, fl);
    check(victim_o, m_vict, req);
    total++;
    if (victim_o > 6'd62) begin
      bad++;
      $display("FAIL R6: victim_o=%0d expected<=62", victim_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [62:0] seen;
    int          distinct;
    logic [5:0]  saved;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(victim_o, 6'd0, "R1 reset state");

    // R2: idle and mode toggling without strobes hold the output
    cyc(1'b1, 1'b0, 1'b0, "R2 idle mode=1");
    cyc(1'b0, 1'b0, 1'b0, "R2 idle mode=0");

    // R3: a full trip up, down and back up, covering both turns
    for (int i = 0; i < 130; i++) cyc(1'b0, 1'b1, 1'b0, "R3 sweep");

    // R7: flush colliding with a fill
    cyc(1'b0, 1'b1, 1'b1, "R7 flush beats fill");
    cyc(1'b0, 1'b1, 1'b0, "R7 sweep restarts at 1");

    // R4 / R5: one full random period
    seen = '0;
    for (int i = 0; i < 63; i++) begin
      cyc(1'b1, 1'b1, 1'b0, "R4 random");
      seen[victim_o] = 1'b1;
    end
    distinct = $countones(seen);
    total++;
    if (distinct != 63) begin
      bad++;
      $display("FAIL R5: distinct=%0d expected=63", distinct);
    end

    // R8: sweep resumes where it stopped after random fills
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, "R8 sweep before");
    saved = victim_o;
    for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1, 1'b0, "R8 random between");
    cyc(1'b0, 1'b1, 1'b0, "R8 sweep resumes");
    total++;
    if (victim_o != saved + 6'd1) begin
      bad++;
      $display("FAIL R8: victim_o=%0d expected=%0d", victim_o, saved + 6'd1);
    end

    // R7: flush in random mode keeps the random register
    cyc(1'b1, 1'b0, 1'b1, "R7 flush random mode");
    cyc(1'b1, 1'b1, 1'b0, "R7 random continues after flush");

    // mixed seeded stimulus
    for (int i = 0; i < 3000; i++) begin
      logic md, f, fl;
      md = 1'($urandom % 2);
      f  = (($urandom % 10) < 7);
      fl = (($urandom % 50) == 0);
      cyc(md, f, fl, "R2/R3/R4/R7/R8 mixed");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule